// File: doc/BRIEF.md
# Shadow-Tag Coherence Directory

This block sits in one bank of a shared second-level cache. It keeps an exact copy of the tag arrays of every first-level cache that the bank serves. The first-level caches are write-through and have only valid and invalid lines, so the copy is enough to know who holds a line. A load miss from a first-level cache carries the way that cache will evict. The directory writes the missing tag into that slot of its copy and raises a fill grant. A store looks up the indexed set across all caches and ways in parallel. For each holder it queues an invalidate (cache id, set, way) and drops the matching copy in the same cycle.

Invalidates leave through a FIFO in the order the directory made them. A store is held off while the FIFO lacks room for the worst case of one invalidate per cache. Requests whose bank-select bits name another bank are accepted and dropped.

Top module: `l2_shadow_dir`

## Requirements
- R1: After reset no shadow entry is valid, `inv_valid` is 0 and `fill_grant` is 0. A store issued after reset invalidates nothing.
- R2: An accepted in-bank load miss raises `fill_grant` for exactly the cycle after acceptance, with `grant_l1` equal to `req_src`. Stores never raise it.
- R3: A load miss writes its tag into the slot picked by `req_src`, the set index and `req_way`. Whatever tag that slot held before is no longer tracked.
- R4: An accepted in-bank store queues one invalidate for every cache whose shadow copy of the indexed set holds the tag, the requesting cache included. Each invalidate carries that cache's id, the set and the way.
- R5: Invalidates from one store come out in ascending cache id. Invalidates from different stores come out in the order the stores were accepted. A head entry that is not taken stays unchanged.
- R6: A shadow entry that produces an invalidate is cleared at the same edge, so a repeated store to that line produces none.
- R7: A load miss also drops any copy of the same tag held in another way of the same set of the same cache, so each cache tracks a line in at most one way.
- R8: Address fields are: offset bits [5:0], set index bits [11:6], tag bits [31:12]. Bank select is bits [7:6] and must equal `BANK_ID` (default 1). A request from another bank is accepted but causes no grant, no invalidate and no shadow update.
- R9: With a store presented, `req_ready` is low while the FIFO has fewer than `NUM_L1` free slots. Load misses are always ready. The FIFO never overflows.
- R10: A store matches only entries of the same set index with an equal tag. The same tag in another set causes no invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_store | input | 1 | 1 = store, 0 = load miss |
| req_src | input | 2 | Requesting first-level cache id |
| req_addr | input | 32 | Byte address |
| req_way | input | 2 | Way the requester will replace (load miss) |
| fill_grant | output | 1 | One-cycle pulse granting a fill |
| grant_l1 | output | 2 | Cache the fill is granted to |
| inv_valid | output | 1 | Invalidate at FIFO head |
| inv_ready | input | 1 | Consumer takes the head invalidate |
| inv_l1 | output | 2 | Target cache of the invalidate |
| inv_set | output | 6 | Set to invalidate |
| inv_way | output | 2 | Way to invalidate |

## Verification
The bench goes after the cases where the shadow copy can drift from the caches. One is a victim way that overwrites an older tag: a design that kept the old tag would send a stray invalidate. One is a second store to a line already invalidated: a design that does not clear on invalidate repeats it. One is a line reloaded into a new way: a design without the R7 cleanup reports the stale lower way. It also checks that a storing cache invalidates itself, that the same tag in another set or another bank is left alone, and that invalidates keep ascending id and store order. A full FIFO must block stores but not loads, or entries would be lost.

// File: rtl/l2_shadow_dir.sv
module l2_shadow_dir #(
  parameter int NUM_L1  = 4,
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 6,
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 1,
  parameter int DEPTH   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_store,
  input  logic [$clog2(NUM_L1)-1:0]  req_src,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [$clog2(WAYS)-1:0]    req_way,
  output logic                       fill_grant,
  output logic [$clog2(NUM_L1)-1:0]  grant_l1,
  output logic                       inv_valid,
  input  logic                       inv_ready,
  output logic [$clog2(NUM_L1)-1:0]  inv_l1,
  output logic [$clog2(SETS)-1:0]    inv_set,
  output logic [$clog2(WAYS)-1:0]    inv_way
);
  localparam int ID_W  = $clog2(NUM_L1);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFS_W - SET_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int ENT_W = ID_W + SET_W + WAY_W;

  logic [TAG_W-1:0] tag_q [NUM_L1][SETS][WAYS];
  logic [WAYS-1:0]  vld_q [NUM_L1][SETS];
  logic [ENT_W-1:0] fifo_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             in_bank, accept, do_load, do_store, pop;
  logic             unused_ofs;

  assign set_idx    = req_addr[OFS_W +: SET_W];
  assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign in_bank    = req_addr[OFS_W +: BANK_W] == BANK_W'(BANK_ID);
  assign unused_ofs = ^req_addr[OFS_W-1:0];
  assign req_ready  = !req_store || (CNT_W'(DEPTH) - cnt) >= CNT_W'(NUM_L1);
  assign accept     = req_valid && req_ready;
  assign do_load    = accept && !req_store && in_bank;
  assign do_store   = accept && req_store && in_bank;
  assign inv_valid  = cnt != '0;
  assign pop        = inv_valid && inv_ready;
  assign {inv_l1, inv_set, inv_way} = fifo_q[rd_ptr];

  logic [WAYS-1:0]  hit      [NUM_L1];
  logic             hit_any  [NUM_L1];
  logic [WAY_W-1:0] hit_way  [NUM_L1];
  logic [ID_W:0]    rank     [NUM_L1];
  logic [ID_W:0]    nhit;

  always_comb begin
    nhit = '0;
    for (int l = 0; l < NUM_L1; l++) begin
      for (int w = 0; w < WAYS; w++)
        hit[l][w] = vld_q[l][set_idx][w] && (tag_q[l][set_idx][w] == req_tag);
      hit_any[l] = |hit[l];
      hit_way[l] = '0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (hit[l][w]) hit_way[l] = WAY_W'(w);
      rank[l] = nhit;
      if (hit_any[l]) nhit = nhit + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_L1; l++)
        for (int s = 0; s < SETS; s++)
          vld_q[l][s] <= '0;
    end else if (do_load) begin
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == req_way)     vld_q[req_src][set_idx][w] <= 1'b1;
        else if (hit[req_src][w])     vld_q[req_src][set_idx][w] <= 1'b0;
    end else if (do_store) begin
      for (int l = 0; l < NUM_L1; l++)
        for (int w = 0; w < WAYS; w++)
          if (hit[l][w]) vld_q[l][set_idx][w] <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (do_load) tag_q[req_src][set_idx][req_way] <= req_tag;

  always_ff @(posedge clk)
    if (do_store)
      for (int l = 0; l < NUM_L1; l++)
        if (hit_any[l])
          fifo_q[wr_ptr + PTR_W'(rank[l])] <= {ID_W'(l), set_idx, hit_way[l]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_store) wr_ptr <= wr_ptr + PTR_W'(nhit);
      if (pop)      rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + (do_store ? CNT_W'(nhit) : '0) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_grant <= 1'b0;
      grant_l1   <= '0;
    end else begin
      fill_grant <= do_load;
      if (do_load) grant_l1 <= req_src;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  p_stall_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_ready) |-> (cnt > CNT_W'(DEPTH - NUM_L1)));
  p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_store && in_bank) |=> (fill_grant && grant_l1 == $past(req_src)));
  p_store_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> !fill_grant);
  p_foreign_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_bank) |=> !fill_grant);
  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable({inv_l1, inv_set, inv_way})));
  p_one_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit[req_src]));
endmodule

// File: tb/l2_shadow_dir_test.sv
module l2_shadow_dir_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, inv_ready = 1'b0;
  logic [1:0] req_src = '0, req_way = '0;
  logic [31:0] req_addr = '0;
  logic req_ready, fill_grant, inv_valid;
  logic [1:0] grant_l1, inv_l1, inv_way;
  logic [5:0] inv_set;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  l2_shadow_dir uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_src(req_src), .req_addr(req_addr), .req_way(req_way),
    .fill_grant(fill_grant), .grant_l1(grant_l1), .inv_valid(inv_valid),
    .inv_ready(inv_ready), .inv_l1(inv_l1), .inv_set(inv_set), .inv_way(inv_way)
  );

  // st[31] src[30:29] set[28:23] tag[22:15] way[14:13] gnt[12] mask[11:8] ways[7:0]
  localparam int NV = 19;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 2'd0, 6'd5, 8'hA1, 2'd2, 1'b1, 4'b0000, 8'h00},
    {1'b0, 2'd1, 6'd5, 8'hA1, 2'd0, 1'b1, 4'b0000, 8'h00},
    {1'b0, 2'd3, 6'd5, 8'hA1, 2'd3, 1'b1, 4'b0000, 8'h00},
    {1'b1, 2'd2, 6'd5, 8'hA1, 2'd0, 1'b0, 4'b1011, 8'b11_00_00_10},
    {1'b1, 2'd0, 6'd5, 8'hA1, 2'd0, 1'b0, 4'b0000, 8'h00},
    {1'b0, 2'd2, 6'd9, 8'hB2, 2'd1, 1'b1, 4'b0000, 8'h00},
    {1'b0, 2'd2, 6'd9, 8'hC3, 2'd1, 1'b1, 4'b0000, 8'h00},
    {1'b1, 2'd0, 6'd9, 8'hB2, 2'd0, 1'b0, 4'b0000, 8'h00},
    {1'b1, 2'd1, 6'd9, 8'hC3, 2'd0, 1'b0, 4'b0100, 8'b00_01_00_00},
    {1'b0, 2'd0, 6'd5, 8'hD4, 2'd0, 1'b1, 4'b0000, 8'h00},
    {1'b1, 2'd0, 6'd5, 8'hD4, 2'd0, 1'b0, 4'b0001, 8'h00},
    {1'b0, 2'd1, 6'd5, 8'hE5, 2'd1, 1'b1, 4'b0000, 8'h00},
    {1'b0, 2'd1, 6'd5, 8'hE5, 2'd3, 1'b1, 4'b0000, 8'h00},
    {1'b1, 2'd3, 6'd5, 8'hE5, 2'd0, 1'b0, 4'b0010, 8'b00_00_11_00},
    {1'b0, 2'd0, 6'd6, 8'hF6, 2'd0, 1'b0, 4'b0000, 8'h00},
    {1'b1, 2'd0, 6'd6, 8'hF6, 2'd0, 1'b0, 4'b0000, 8'h00},
    {1'b0, 2'd3, 6'd5, 8'h97, 2'd1, 1'b1, 4'b0000, 8'h00},
    {1'b1, 2'd3, 6'd9, 8'h97, 2'd0, 1'b0, 4'b0000, 8'h00},
    {1'b1, 2'd1, 6'd5, 8'h97, 2'd0, 1'b0, 4'b1000, 8'b01_00_00_00}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit st, input logic [1:0] src, input logic [5:0] set,
                       input logic [7:0] tag, input logic [1:0] way);
    req_valid = 1'b1; req_store = st; req_src = src; req_way = way;
    req_addr  = {12'h000, tag, set, 6'h15};
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input logic [3:0] mask, input logic [7:0] ways, input logic [5:0] set, input string req);
    inv_ready = 1'b1;
    for (int l = 0; l < 4; l++) begin
      if (mask[l]) begin
        chk(inv_valid && inv_l1 == 2'(l) && inv_way == ways[2*l +: 2] && inv_set == set, req,
            "invalidate {l1,set,way}", {inv_valid, inv_l1, inv_set, inv_way},
            {1'b1, 2'(l), set, ways[2*l +: 2]});
        @(posedge clk); @(negedge clk);
      end
    end
    chk(!inv_valid, req, "no extra invalidate", inv_valid, 0);
    inv_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    req_store = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!inv_valid && !fill_grant, "R1", "reset outputs", {inv_valid, fill_grant}, 0);
    chk(req_ready, "R1", "store ready after reset", req_ready, 1);
    req_store = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      issue(v[31], v[30:29], v[28:23], v[22:15], v[14:13]);
      chk(fill_grant == v[12] && (!v[12] || grant_l1 == v[30:29]), "R2 R3 R8",
          $sformatf("grant vec %0d", i), {fill_grant, grant_l1}, {v[12], v[12] ? v[30:29] : grant_l1});
      drain(v[11:8], v[7:0], v[28:23], $sformatf("R4 R5 R6 R7 R10 vec %0d", i));
      @(negedge clk);
      chk(!fill_grant, "R2", "grant is one cycle", fill_grant, 0);
    end

    // R9: fill FIFO with two four-sharer stores, then stall
    for (int l = 0; l < 4; l++) begin
      issue(1'b0, 2'(l), 6'd9, 8'h11, 2'd0);
      issue(1'b0, 2'(l), 6'd9, 8'h22, 2'd2);
    end
    issue(1'b1, 2'd0, 6'd9, 8'h11, 2'd0);
    issue(1'b1, 2'd3, 6'd9, 8'h22, 2'd0);
    req_valid = 1'b1; req_store = 1'b1; req_src = 2'd1;
    req_addr = {12'h000, 8'h33, 6'd9, 6'h00};
    #0 chk(!req_ready, "R9", "store stalled on full FIFO", req_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(!req_ready, "R9", "store still stalled", req_ready, 0);
    req_store = 1'b0; req_way = 2'd3;
    #0 chk(req_ready, "R9", "load ready while FIFO full", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(fill_grant && grant_l1 == 2'd1, "R9", "load granted while FIFO full", {fill_grant, grant_l1}, 3'b101);
    inv_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk(inv_valid && inv_l1 == 2'(k % 4) && inv_way == (k < 4 ? 2'd0 : 2'd2) && inv_set == 6'd9,
          "R5", $sformatf("cross-store order %0d", k), {inv_valid, inv_l1, inv_way},
          {1'b1, 2'(k % 4), (k < 4 ? 2'd0 : 2'd2)});
      @(posedge clk); @(negedge clk);
    end
    chk(!inv_valid, "R9", "exactly eight queued", inv_valid, 0);
    inv_ready = 1'b0;
    req_store = 1'b1;
    #0 chk(req_ready, "R9", "store ready after drain", req_ready, 1);
    req_store = 1'b0;

    // R1: reset clears the directory
    issue(1'b0, 2'd2, 6'd13, 8'h77, 2'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!fill_grant && !inv_valid, "R1", "outputs in reset", {fill_grant, inv_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b1, 2'd0, 6'd13, 8'h77, 2'd0);
    drain(4'b0000, 8'h00, 6'd13, "R1 directory cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule